// File: doc/BRIEF.md
# Serial Command Slave with Frame-Length Validation

This block is the serial-peripheral slave front end of a multi-channel driver. An external master lowers the chip select and clocks 16-bit command words in on the data input. While it does so, the block shifts a 16-bit status word out, most significant bit first. When the chip select is released, the block counts the clocked bits. It accepts the frame only if the count is a nonzero multiple of the word width. An accepted frame produces a one-cycle write strobe that carries the address and data of the last word received to a register file outside this block.

Bits clocked in are shifted through the same register that holds the status word. As a result, after the first word the output repeats the input bits from the start of the frame, so several devices can be chained on one select line. Each device keeps the last word that reached it. Fault events arrive as parallel pulses or levels and are held in sticky bits, grouped into several status words. A 2-bit selector picks which word is returned. The selector is written by an initialization command, which is any accepted word whose address is 00000. Held bits are cleared once the word that showed them has been read in an accepted frame and the fault has gone away. A frame of invalid length changes nothing.

The serial pins are sampled with the block clock. The clock must run at least eight times faster than the serial clock. The serial interface uses mode 0: data is sampled on the rising serial-clock edge and the output changes on the falling edge.

Top module: `spi_frame_slave`

## Requirements
- R1: `so_oe` is low while chip select is high (inactive). It is high within three clock cycles after chip select goes low.
- R2: When chip select falls, the currently selected status word is loaded. `so` shows its bit 15 first. Each falling serial-clock edge advances `so` to the next lower bit.
- R3: Bits clocked out after the first 16 of a frame are the bits received on `si` at the start of that frame, in the same order.
- R4: On release of chip select after N bits, where N is a nonzero multiple of 16, `wr_stb` pulses for exactly one cycle. `wr_addr` then carries bits 15:11 and `wr_data` carries bits 10:0 of the last 16 bits received.
- R5: A frame whose bit count is zero or not a multiple of 16 produces no strobe, does not change the selector and clears no status bit.
- R6: An accepted word with address 00000 sets the selector to its bits 1:0. Selector value k returns status word k, which is bits 16k+15 down to 16k of `fault_in`. The selector resets to 0.
- R7: A one-cycle high on any `fault_in` bit sets the matching status bit, and the bit stays set until it is cleared as described in R8.
- R8: An accepted frame clears only those bits of the word it read that were set when chip select fell and whose `fault_in` is low at release. Bits set during the frame, or whose fault is still present, remain set.
- R9: After reset, no strobe is issued, the selector is 0 and all status bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the three-state `so` pad driver |
| wr_stb | output | 1 | One-cycle strobe for an accepted word |
| wr_addr | output | 5 | Address field of the accepted word |
| wr_data | output | 11 | Data field of the accepted word |
| fault_in | input | 64 | Fault events, four 16-bit status words |

## Verification
Some rules are checked by the assertions on every cycle. A strobe is never wider than one cycle and only follows a bit count that is a nonzero multiple of 16. The selector and the held status bits never change without a strobe. The first bit driven when the output enables is the MSB of the selected word. The scenarios are needed to show the rest: the shift-out order, the daisy-chain echo over a 32-bit frame, the address and data fields that reach the register file, and the selector picking a different word. They also cover the clear rules: a fault still present at release, and a fault that arrives mid-frame.

// File: rtl/spi_frame_slave.sv
module spi_frame_slave #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int NUM_WORDS = 4,
  parameter int INIT_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk,
  input  logic                        cs_n,
  input  logic                        si,
  output logic                        so,
  output logic                        so_oe,
  output logic                        wr_stb,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [WORD_W-ADDR_W-1:0]    wr_data,
  input  logic [NUM_WORDS*WORD_W-1:0] fault_in
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int SEL_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int ALL_W  = NUM_WORDS * WORD_W;

  logic [2:0] sclk_p, cs_p;
  logic [1:0] si_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      si_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      si_p   <= {si_p[0], si};
    end

  wire active    = ~cs_p[2];
  wire sclk_rise = active & sclk_p[1] & ~sclk_p[2];
  wire sclk_fall = active & ~sclk_p[1] & sclk_p[2];
  wire cs_fall   = ~cs_p[1] & cs_p[2];
  wire cs_rise   = cs_p[1] & ~cs_p[2];

  logic [WORD_W-1:0] sr, snap;
  logic              so_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              bits_seen;
  logic [SEL_W-1:0]  sel, rd_sel;
  logic [ALL_W-1:0]  sticky, clr;

  wire [WORD_W-1:0] cur_word = sticky[sel*WORD_W +: WORD_W];
  wire              frame_ok = cs_rise & bits_seen & (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr        <= '0;
      so_q      <= 1'b0;
      bit_cnt   <= '0;
      bits_seen <= 1'b0;
      snap      <= '0;
      rd_sel    <= '0;
    end else if (cs_fall) begin
      sr        <= cur_word;
      so_q      <= cur_word[WORD_W-1];
      snap      <= cur_word;
      rd_sel    <= sel;
      bit_cnt   <= '0;
      bits_seen <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sr        <= {sr[WORD_W-2:0], si_p[1]};
        bit_cnt   <= bit_cnt + 1'b1;
        bits_seen <= 1'b1;
      end
      if (sclk_fall) so_q <= sr[WORD_W-1];
    end

  always_comb begin
    clr = '0;
    if (frame_ok)
      clr[rd_sel*WORD_W +: WORD_W] = snap & ~fault_in[rd_sel*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sticky  <= '0;
      sel     <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sticky <= (sticky & ~clr) | fault_in;
      wr_stb <= frame_ok;
      if (frame_ok) begin
        wr_addr <= sr[WORD_W-1 -: ADDR_W];
        wr_data <= sr[DATA_W-1:0];
        if (sr[WORD_W-1 -: ADDR_W] == ADDR_W'(INIT_ADDR)) sel <= sr[SEL_W-1:0];
      end
    end

  assign so    = so_q;
  assign so_oe = active;
endmodule

module spi_frame_slave_chk #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  parameter int SEL_W     = 2,
  parameter int CNT_W     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        so,
  input logic                        so_oe,
  input logic                        wr_stb,
  input logic [CNT_W-1:0]            bit_cnt,
  input logic                        bits_seen,
  input logic [SEL_W-1:0]            sel,
  input logic [NUM_WORDS*WORD_W-1:0] sticky,
  input logic                        cur_msb
);
  // R4
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R5
  stb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bits_seen && bit_cnt == '0));
  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel) |-> wr_stb);
  // R8
  clr_only_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sticky & $past(sticky)) != '0) |-> wr_stb);
  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> so == $past(cur_msb));
  // R1
  idle_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !so_oe);
endmodule

bind spi_frame_slave spi_frame_slave_chk #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe), .wr_stb(wr_stb),
  .bit_cnt(bit_cnt), .bits_seen(bits_seen), .sel(sel), .sticky(sticky),
  .cur_msb(cur_word[WORD_W-1])
);

// File: tb/tb_spi_frame_slave.sv
module tb_spi_frame_slave;
  logic        clk = 0, rst_n = 0, sclk = 0, cs_n = 1, si = 0;
  logic        so, so_oe, wr_stb;
  logic [4:0]  wr_addr;
  logic [10:0] wr_data;
  logic [63:0] fault_in = '0;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [4:0]  last_addr;
  logic [10:0] last_data;
  logic        oe_mid;

  spi_frame_slave dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) if (wr_stb) begin
    wr_cnt    <= wr_cnt + 1;
    last_addr <= wr_addr;
    last_data <= wr_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    cs_n = 0;
    clks(4);
    oe_mid = so_oe;
    for (int i = 0; i < n; i++) begin
      si = din[n-1-i];
      clks(4);
      dout[n-1-i] = so;
      sclk = 1;
      clks(4);
      sclk = 0;
    end
    clks(4);
    cs_n = 1;
    clks(6);
  endtask

  task automatic pulse(input logic [63:0] m);
    @(negedge clk) fault_in = m;
    @(negedge clk) fault_in = '0;
  endtask

  task automatic t_reset;
    chk("R9 so_oe idle", so_oe, 0);
    chk("R1 so_oe with cs high", so_oe, 0);
    chk("R9 no strobe", wr_cnt, 0);
  endtask

  task automatic t_read_clear;
    logic [63:0] d;
    int c0 = wr_cnt;
    pulse(64'hA5C3);
    frame(16, {48'h0, 5'b01010, 11'h155}, d);
    chk("R1 so_oe during frame", oe_mid, 1);
    chk("R1 so_oe after frame", so_oe, 0);
    chk("R2 R7 status shifted out", d[15:0], 16'hA5C3);
    chk("R4 one strobe", wr_cnt, c0 + 1);
    chk("R4 address", last_addr, 5'b01010);
    chk("R4 data", last_data, 11'h155);
    frame(16, 64'h5000, d);
    chk("R8 cleared after read", d[15:0], 0);
  endtask

  task automatic t_daisy;
    logic [63:0] d;
    frame(32, {32'h0, 16'h1234, 16'h7ABC}, d);
    chk("R3 first word is status", d[31:16], 0);
    chk("R3 echo of first bits", d[15:0], 16'h1234);
    chk("R4 last word address", last_addr, 5'h0F);
    chk("R4 last word data", last_data, 11'h2BC);
  endtask

  task automatic t_invalid;
    logic [63:0] d;
    int c0;
    pulse(64'h0F00);
    c0 = wr_cnt;
    frame(17, {47'h0, 16'h0002, 1'b0}, d);
    chk("R5 17-bit no strobe", wr_cnt, c0);
    frame(0, 64'h0, d);
    chk("R5 zero-bit no strobe", wr_cnt, c0);
    frame(8, 64'h00, d);
    chk("R5 8-bit no strobe", wr_cnt, c0);
    frame(16, 64'h5000, d);
    chk("R5 status kept, selector unchanged", d[15:0], 16'h0F00);
  endtask

  task automatic t_select;
    logic [63:0] d;
    pulse(64'h1234 << 32);
    frame(16, 64'h0002, d);
    chk("R6 init word address", last_addr, 0);
    chk("R6 read word0 before change", d[15:0], 0);
    frame(16, 64'h0003, d);
    chk("R6 selector 2 returns word2", d[15:0], 16'h1234);
    frame(16, 64'h0000, d);
    chk("R6 selector 3 returns word3", d[15:0], 0);
  endtask

  task automatic t_hold;
    logic [63:0] d;
    @(negedge clk) fault_in = 64'h0020;
    clks(2);
    frame(16, 64'h5000, d);
    chk("R7 level fault read", d[15:0], 16'h0020);
    frame(16, 64'h5000, d);
    chk("R8 present fault not cleared", d[15:0], 16'h0020);
    @(negedge clk) fault_in = '0;
    frame(16, 64'h5000, d);
    chk("R8 removed fault still shown", d[15:0], 16'h0020);
    frame(16, 64'h5000, d);
    chk("R8 removed fault cleared", d[15:0], 0);
    fork
      frame(16, 64'h5000, d);
      begin clks(60); pulse(64'h0200); end
    join
    chk("R8 frame before event", d[15:0], 0);
    frame(16, 64'h5000, d);
    chk("R8 mid-frame event kept", d[15:0], 16'h0200);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clks(3);
    rst_n = 1;
    clks(3);
    t_reset;
    t_read_clear;
    t_daisy;
    t_invalid;
    t_select;
    t_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule